// File: doc/BRIEF.md
# Page Write Buffer with Self-Timed Commit

This block stands between a two-wire serial slave front end and a 256-location, 8-bit storage array. During one write transaction it gathers up to sixteen data bytes into a small page buffer. It does not touch the array while the transaction is still running. When the front end reports the STOP that closes the transaction, the block runs a self-timed programming window of `PROG_CYCLES` clock cycles and raises `busy` for exactly that long. The front end uses `busy` to stay silent on the bus.

The front end pulses `txn_start` on each START. It pulses `addr_load` with the word address once that address byte has arrived. It pulses `byte_stb` with each data byte after that. The upper four address bits select the page and stay fixed. The lower four bits form an entry pointer that advances with each byte and wraps inside the page. During the window, the block scans the sixteen buffer entries in ascending order, one per cycle. It issues an array write only for the entries that received a byte in the current transaction. `busy` falls by itself when the count runs out. A one-byte write follows the same path as a page write of length one.

Top module: `page_commit_buf`

## Requirements
- R1: While reset is held and directly after it, `busy` is 0 and `mem_we` is 0.
- R2: Data byte number k (counting from 0) of a transaction lands at array address {A[7:4], (A[3:0]+k) mod 16}, where A is the word address loaded with `addr_load`. The upper four address bits never change within a transaction.
- R3: After a commit, only the addresses that received a byte in that transaction differ from their previous contents.
- R4: No array write happens and `busy` stays 0 while bytes are being collected. The commit starts only on `stop_pulse`.
- R5: After a `stop_pulse` that follows at least one byte, `busy` is 1 from the next cycle for exactly `PROG_CYCLES` cycles. It then returns to 0 without any input.
- R6: `mem_we` is asserted only while `busy` is 1. There is exactly one write per buffered entry in each window, and the low four address bits strictly increase across the window.
- R7: A `stop_pulse` in a transaction that received no data byte leaves `busy` at 0 and causes no write.
- R8: While `busy` is 1, `txn_start`, `addr_load`, `byte_stb` and `stop_pulse` have no effect on the buffer, the mask, the address or the window length.
- R9: With more than 16 bytes, the pointer wraps within the page and a later byte replaces the earlier byte in the same entry. The commit then writes 16 locations.
- R10: A single data byte is committed through the same window as a page, with one write and the full `PROG_CYCLES` busy time.
- R11: `txn_start` clears the entry mask. Entries from an earlier transaction are not written again by a later one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_start | input | 1 | START seen by the front end (one-cycle pulse) |
| addr_load | input | 1 | Word address byte valid on `addr_in` |
| addr_in | input | 8 | Word address: page and starting entry |
| byte_stb | input | 1 | Data byte valid on `byte_in` |
| byte_in | input | 8 | Data byte |
| stop_pulse | input | 1 | STOP that ends the transaction (one-cycle pulse) |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | 8 | Array write address |
| mem_wdata | output | 8 | Array write data |
| busy | output | 1 | Programming window active; the front end must ignore the bus |

## Verification
The hardest case to reach is the lockout: the block has to receive a full set of bus events while `busy` is high, and the bench must then show that none of them left a trace. The bench drives junk START, address, byte and STOP strobes throughout a window. It then issues a second STOP with no START. Because the mask survives until the next START, this STOP commits the original bytes again. A changed write count, different data or a different window length would show that something leaked in during the lockout. Wrap-around and overwrite come from a sweep over pages, starting entries and lengths from 0 to 18.

// File: rtl/page_commit_buf.sv
module page_commit_buf #(
  parameter int AW          = 8,
  parameter int DW          = 8,
  parameter int PW          = 4,
  parameter int PROG_CYCLES = 2000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          txn_start,
  input  logic          addr_load,
  input  logic [AW-1:0] addr_in,
  input  logic          byte_stb,
  input  logic [DW-1:0] byte_in,
  input  logic          stop_pulse,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          busy
);
  localparam int PD = 1 << PW;
  localparam int CW = $clog2(PROG_CYCLES + 1);

  logic [DW-1:0]    pbuf [PD];
  logic [PD-1:0]    valid;
  logic [AW-PW-1:0] page;
  logic [PW-1:0]    ptr;
  logic             busy_q;
  logic [CW-1:0]    cnt;

  wire [PW-1:0] scan     = cnt[PW-1:0];
  wire          scanning = busy_q && (cnt < CW'(PD));
  wire          accept   = !busy_q;

  assign busy      = busy_q;
  assign mem_we    = scanning && valid[scan];
  assign mem_addr  = {page, scan};
  assign mem_wdata = pbuf[scan];

  always_ff @(posedge clk) begin
    if (accept && byte_stb) pbuf[ptr] <= byte_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt    <= '0;
      valid  <= '0;
      page   <= '0;
      ptr    <= '0;
    end else if (busy_q) begin
      if (cnt == CW'(PROG_CYCLES - 1)) begin
        busy_q <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      if (txn_start) valid <= '0;
      if (addr_load) {page, ptr} <= addr_in;
      if (byte_stb) begin
        valid[ptr] <= 1'b1;
        ptr        <= ptr + 1'b1;
      end
      if (stop_pulse && |valid) begin
        busy_q <= 1'b1;
        cnt    <= '0;
      end
    end
  end
endmodule

module page_commit_chk #(
  parameter int AW          = 8,
  parameter int PW          = 4,
  parameter int PD          = 16,
  parameter int PROG_CYCLES = 2000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          addr_load,
  input logic [AW-1:0] addr_in,
  input logic          stop_pulse,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          busy,
  input logic [PD-1:0] vmask
);
  int unsigned      run;
  logic [AW-PW-1:0] pg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 0;
      pg  <= '0;
    end else begin
      run <= busy ? run + 1 : 0;
      if (addr_load && !busy) pg <= addr_in[AW-1:PW];
    end
  end

  // R5
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run == PROG_CYCLES);

  // R4
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_pulse));

  // R6
  we_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  // R2
  page_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr[AW-1:PW] == pg);

  // R7
  empty_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_pulse && !busy && vmask == '0) |=> !busy);
endmodule

bind page_commit_buf page_commit_chk #(
  .AW(AW), .PW(PW), .PD(1 << PW), .PROG_CYCLES(PROG_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
  .stop_pulse(stop_pulse), .mem_we(mem_we), .mem_addr(mem_addr),
  .busy(busy), .vmask(valid)
);

// File: tb/tb_page_commit_buf.sv
`timescale 1ns/1ps
module tb_page_commit_buf;
  localparam int PROG = 20;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       txn_start = 0, addr_load = 0, byte_stb = 0, stop_pulse = 0;
  logic [7:0] addr_in = 0, byte_in = 0;
  logic       mem_we, busy;
  logic [7:0] mem_addr, mem_wdata;

  page_commit_buf #(.PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .addr_load(addr_load),
    .addr_in(addr_in), .byte_stb(byte_stb), .byte_in(byte_in),
    .stop_pulse(stop_pulse), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .busy(busy)
  );

  logic [7:0] tb_mem [256];
  logic [7:0] exp_mem [256];
  int checks = 0, errors = 0;
  int wr_cnt = 0, we_idle = 0, order_bad = 0, last_lo = -1;
  bit done = 0;

  always @(negedge clk) if (rst_n && mem_we) begin
    tb_mem[mem_addr] = mem_wdata;
    wr_cnt++;
    if (!busy) we_idle++;
    if (int'(mem_addr[3:0]) <= last_lo) order_bad++;
    last_lo = int'(mem_addr[3:0]);
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic mem_cmp(string req);
    int mis = 0;
    for (int i = 0; i < 256; i++) if (tb_mem[i] !== exp_mem[i]) mis++;
    chk(mis == 0, req, mis, 0);
  endtask

  task automatic do_stop(bit junk, output int bl);
    wr_cnt = 0; we_idle = 0; order_bad = 0; last_lo = -1;
    stop_pulse = 1; tick; stop_pulse = 0;
    bl = 0;
    while (busy && bl < 1000) begin
      if (junk) begin
        txn_start = 1; addr_load = 1; addr_in = 8'hFF;
        byte_stb = 1; byte_in = 8'h5A; stop_pulse = 1;
      end
      bl++;
      tick;
    end
    txn_start = 0; addr_load = 0; byte_stb = 0; stop_pulse = 0;
    tick;
  endtask

  task automatic run_txn(int pg, int lo, int n, bit junk, output int bl);
    int pre;
    txn_start = 1; tick; txn_start = 0;
    addr_in = 8'((pg << 4) | lo); addr_load = 1; tick; addr_load = 0;
    wr_cnt = 0;
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      d = 8'(pg * 37 + lo * 11 + k * 13 + n * 7 + 1);
      byte_in = d; byte_stb = 1; tick; byte_stb = 0;
      exp_mem[(pg << 4) | ((lo + k) % 16)] = d;
    end
    tick;
    pre = wr_cnt;
    chk(pre == 0 && busy == 0, "R4 no write/busy before STOP", pre + int'(busy), 0);
    do_stop(junk, bl);
  endtask

  initial begin
    int bl;
    for (int i = 0; i < 256; i++) begin tb_mem[i] = 0; exp_mem[i] = 0; end
    tick; tick;
    chk(busy == 0 && mem_we == 0, "R1 reset outputs", int'(busy) + int'(mem_we), 0);
    rst_n = 1; tick; tick;
    chk(busy == 0 && mem_we == 0, "R1 after reset", int'(busy) + int'(mem_we), 0);

    for (int p = 0; p < 3; p++)
      for (int l = 0; l < 3; l++)
        for (int n = 0; n <= 18; n++) begin
          int pg, lo, ew;
          pg = (p == 0) ? 0 : (p == 1) ? 5 : 15;
          lo = (l == 0) ? 0 : (l == 1) ? 7 : 15;
          run_txn(pg, lo, n, 0, bl);
          ew = (n > 16) ? 16 : n;
          if (n == 0) begin
            chk(bl == 0 && wr_cnt == 0, "R7 empty STOP", bl + wr_cnt, 0);
          end else begin
            chk(bl == PROG, (n == 1) ? "R10 single byte busy" : "R5 busy length", bl, PROG);
            chk(wr_cnt == ew, (n > 16) ? "R9 wrapped write count" : "R6 write count", wr_cnt, ew);
            chk(we_idle == 0 && order_bad == 0, "R6 order/window", we_idle + order_bad, 0);
          end
          mem_cmp(n > 16 ? "R9 overwrite contents" : "R2 R3 contents");
        end

    run_txn(3, 4, 5, 1, bl);
    chk(bl == PROG, "R8 window length under junk", bl, PROG);
    mem_cmp("R8 contents after junk");
    do_stop(0, bl);
    chk(bl == PROG, "R8 recommit busy", bl, PROG);
    chk(wr_cnt == 5, "R8 recommit writes", wr_cnt, 5);
    mem_cmp("R8 recommit contents");

    run_txn(6, 0, 3, 0, bl);
    run_txn(9, 2, 1, 0, bl);
    chk(wr_cnt == 1, "R11 mask cleared at START", wr_cnt, 1);
    mem_cmp("R11 contents");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule